// File: doc/BRIEF.md
# Symbol Error Patch Engine

This block repairs a page buffer after a Reed-Solomon decoder has found the faulty symbols. The decoder hands over, one at a time, a 12-bit error value and the index of the 12-bit symbol it belongs to. The engine works out which bytes of the buffer that symbol overlaps and XORs the matching slice of the error value into each byte through a read-modify-write on a byte-wide buffer port.

The buffer is one flat byte space: the data page comes first (bytes 0 to PAGE_BYTES-1) and the spare bytes follow straight after. Symbols are packed across that space without gaps, so a symbol either starts on a byte boundary (odd index) or halfway into a byte (even index). Symbol 0 is the only one cut short: its top four bits lie outside the buffer. The symbol whose bytes span the end of the page and the start of the spare area needs no special path, because the two regions are contiguous in the byte space.

The engine counts the patterns it has fully written and stops after the per-page limit. A failure pulse from the decoder marks the page as beyond repair: from then on nothing in the buffer is touched until a new page is started.

Top module: `ecc_symbol_fixer`

## Requirements
- R1: For an odd symbol index p, byte floor(3p/2) is XORed with pattern bits [11:4] and byte floor(3p/2)+1 is XORed with pattern bits [3:0] placed in bits [7:4] (bits [3:0] of the mask are zero).
- R2: For an even index p greater than zero, byte 3p/2-1 is XORed with pattern bits [11:8] placed in bits [3:0] (upper nibble of the mask zero) and byte 3p/2 is XORed with pattern bits [7:0].
- R3: For symbol 0 only byte 0 is changed, XORed with pattern bits [7:0]; pattern bits [11:8] are discarded and only one read-modify-write is issued.
- R4: Spare bytes sit at buffer addresses PAGE_BYTES and up, so symbol 1365 updates byte 2047 with bits [11:4] and spare byte 0 (address 2048) with bits [3:0] in its high nibble, and symbols above 1365 follow R1 and R2 into the spare area up to the last symbol 1407.
- R5: Each byte update is a read cycle (buf_rd) followed in the very next cycle by a write (buf_wr) to the same address with buf_wdata equal to the returned byte XOR the mask; req_ready is low for 4 cycles after a two-byte request and 2 cycles after a one-byte request.
- R6: A request whose symbol index is beyond the last whole symbol in the buffer (above 1407 by default) is accepted and dropped: no buffer access, no count change, req_ready stays high.
- R7: corr_count rises by exactly one when the last write of a pattern is performed; once it equals MAX_ERR (4) further requests are accepted and dropped with no buffer access.
- R8: While uncorrectable is high, requests are accepted and dropped with no buffer read or write and corr_count is frozen.
- R9: page_fail high in a cycle sets uncorrectable from the next cycle, suppresses any buffer read or write in that same cycle and abandons the rest of the pattern in progress without counting it.
- R10: After reset corr_count is 0, uncorrectable is 0, req_ready is 1 and neither buf_rd nor buf_wr is asserted.
- R11: A new_page pulse clears corr_count and uncorrectable, after which requests are applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_page | input | 1 | Start of a new page: clears count and failure flag |
| page_fail | input | 1 | Decoder reports the page as uncorrectable |
| req_valid | input | 1 | Error request present |
| req_ready | output | 1 | Engine can take a request |
| req_pos | input | SYM_IDX_W (11) | Symbol index of the error |
| req_pat | input | 12 | Error value to XOR into the symbol |
| buf_rd | output | 1 | Buffer read strobe; data returns next cycle |
| buf_wr | output | 1 | Buffer write strobe |
| buf_addr | output | ADDR_W (12) | Byte address in page-then-spare space |
| buf_wdata | output | 8 | Byte to write |
| buf_rdata | input | 8 | Byte read, valid the cycle after buf_rd |
| corr_count | output | CNT_W (3) | Patterns applied in this page |
| uncorrectable | output | 1 | Page marked beyond repair |

## Verification
The two functions that can land in one cycle are the write half of a byte update and the failure report from the decoder. The bench raises page_fail for exactly one cycle timed to hit the second write of a two-byte symbol, and separately to hit the first write, then compares the whole buffer with a reference copy: in the first case only the first byte may have changed, in the second none, and in both the count must not move while uncorrectable must be set. Random symbol and pattern streams per page, mixed with directed indices at 0, the page/spare straddle, the last symbol and just past it, check the address and nibble arithmetic against bench functions.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int SYM_BITS = 12;

    typedef logic [7:0]          byte_t;
    typedef logic [SYM_BITS-1:0] sym_t;

    // Masks for the one or two bytes a symbol overlaps.
    // back: first byte sits one below floor(3p/2) (even, nonzero index).
    typedef struct packed {
        logic  pair;
        logic  back;
        byte_t m0;
        byte_t m1;
    } mask_plan_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_WR_A,
        ST_RD_B,
        ST_WR_B
    } seq_state_e;

    function automatic mask_plan_t split_pattern(input logic is_zero,
                                                 input logic is_odd,
                                                 input sym_t pat);
        mask_plan_t mp;
        mp = '0;
        if (is_zero) begin
            mp.pair = 1'b0;
            mp.back = 1'b0;
            mp.m0   = pat[7:0];
            mp.m1   = 8'h00;
        end else if (is_odd) begin
            mp.pair = 1'b1;
            mp.back = 1'b0;
            mp.m0   = pat[11:4];
            mp.m1   = {pat[3:0], 4'h0};
        end else begin
            mp.pair = 1'b1;
            mp.back = 1'b1;
            mp.m0   = {4'h0, pat[11:8]};
            mp.m1   = pat[7:0];
        end
        return mp;
    endfunction

endpackage

// File: rtl/sym_map.sv
module sym_map
    import ecc_fix_pkg::*;
#(
    parameter int SYM_COUNT = 1408,
    parameter int SYM_IDX_W = 11,
    parameter int ADDR_W    = 12
) (
    input  logic [SYM_IDX_W-1:0] pos,
    input  sym_t                 pat,
    output logic                 in_range,
    output logic [ADDR_W-1:0]    first_addr,
    output mask_plan_t           plan
);
    localparam int PROD_W = SYM_IDX_W + 2;

    logic [PROD_W-1:0] tri3;
    logic [PROD_W-1:0] half;

    always_comb begin
        tri3       = {2'b00, pos} + {1'b0, pos, 1'b0};
        half       = tri3 >> 1;
        plan       = split_pattern(pos == '0, pos[0], pat);
        first_addr = ADDR_W'(half - PROD_W'(plan.back));
        in_range   = (int'(pos) < SYM_COUNT);
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import ecc_fix_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  mask_plan_t        plan,
    input  logic              kill,
    input  byte_t             buf_rdata,
    output logic              idle,
    output logic              buf_rd,
    output logic              buf_wr,
    output logic [ADDR_W-1:0] buf_addr,
    output byte_t             buf_wdata,
    output logic              done
);
    seq_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    mask_plan_t        plan_q;
    logic              second_half;

    always_comb begin
        second_half = (state == ST_RD_B) || (state == ST_WR_B);
        idle        = (state == ST_IDLE);
        buf_addr    = second_half ? addr_q + ADDR_W'(1) : addr_q;
        buf_rd      = ((state == ST_RD_A) || (state == ST_RD_B)) && !kill;
        buf_wr      = ((state == ST_WR_A) || (state == ST_WR_B)) && !kill;
        buf_wdata   = buf_rdata ^ (second_half ? plan_q.m1 : plan_q.m0);
        done        = buf_wr && ((state == ST_WR_B) ||
                                 ((state == ST_WR_A) && !plan_q.pair));
    end

    always_comb begin
        state_nx = state;
        if (state == ST_IDLE) begin
            if (start) state_nx = ST_RD_A;
        end else if (kill) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_RD_A: state_nx = ST_WR_A;
                ST_WR_A: state_nx = plan_q.pair ? ST_RD_B : ST_IDLE;
                ST_RD_B: state_nx = ST_WR_B;
                ST_WR_B: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            plan_q <= '0;
        end else begin
            state <= state_nx;
            if (idle && start) begin
                addr_q <= first_addr;
                plan_q <= plan;
            end
        end
    end

    // R5: a write always lands one cycle after a read of the same byte
    assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> ($past(buf_rd) && (buf_addr == $past(buf_addr))));

    // R5: read and write strobes never overlap
    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(buf_rd && buf_wr));

endmodule

// File: rtl/fail_tally.sv
module fail_tally #(
    parameter int MAX_ERR = 4,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    input  logic             set_fail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             failed
);
    always_comb full = (count == CNT_W'(MAX_ERR));

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            failed <= 1'b0;
        end else begin
            failed <= set_fail || (failed && !clear);
            if (clear)             count <= '0;
            else if (inc && !full) count <= count + CNT_W'(1);
        end
    end

    // R7: count stays within the per-page limit
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= MAX_ERR);

    // R7: outside a clear the count moves by at most one
    assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(clear) |-> ((count == $past(count)) ||
                           (count == $past(count) + CNT_W'(1))));

endmodule

// File: rtl/ecc_symbol_fixer.sv
module ecc_symbol_fixer
    import ecc_fix_pkg::*;
#(
    parameter  int PAGE_BYTES  = 2048,
    parameter  int SPARE_BYTES = 64,
    parameter  int MAX_ERR     = 4,
    localparam int BUF_BYTES   = PAGE_BYTES + SPARE_BYTES,
    localparam int ADDR_W      = $clog2(BUF_BYTES),
    localparam int SYM_COUNT   = (BUF_BYTES * 8) / SYM_BITS,
    localparam int SYM_IDX_W   = $clog2(SYM_COUNT + 1),
    localparam int CNT_W       = $clog2(MAX_ERR + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 new_page,
    input  logic                 page_fail,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SYM_IDX_W-1:0] req_pos,
    input  logic [SYM_BITS-1:0]  req_pat,
    output logic                 buf_rd,
    output logic                 buf_wr,
    output logic [ADDR_W-1:0]    buf_addr,
    output logic [7:0]           buf_wdata,
    input  logic [7:0]           buf_rdata,
    output logic [CNT_W-1:0]     corr_count,
    output logic                 uncorrectable
);
    logic              in_range;
    logic [ADDR_W-1:0] first_addr;
    mask_plan_t        plan;
    logic              accept, drop, start, kill, done, full, idle;

    sym_map #(
        .SYM_COUNT (SYM_COUNT),
        .SYM_IDX_W (SYM_IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_map (
        .pos        (req_pos),
        .pat        (req_pat),
        .in_range   (in_range),
        .first_addr (first_addr),
        .plan       (plan)
    );

    always_comb begin
        req_ready = idle;
        accept    = req_valid && req_ready;
        drop      = uncorrectable || full || !in_range;
        start     = accept && !drop;
        kill      = uncorrectable || page_fail;
    end

    rmw_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .first_addr (first_addr),
        .plan       (plan),
        .kill       (kill),
        .buf_rdata  (buf_rdata),
        .idle       (idle),
        .buf_rd     (buf_rd),
        .buf_wr     (buf_wr),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .done       (done)
    );

    fail_tally #(
        .MAX_ERR (MAX_ERR),
        .CNT_W   (CNT_W)
    ) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear    (new_page),
        .inc      (done),
        .set_fail (page_fail),
        .count    (corr_count),
        .full     (full),
        .failed   (uncorrectable)
    );

    // R8: a page marked beyond repair sees no buffer traffic
    assert_quiet_when_failed_R8: assert property (@(posedge clk) disable iff (rst)
        uncorrectable |-> (!buf_rd && !buf_wr));

    // R9: a failure report blocks a write in the same cycle
    assert_fail_blocks_write_R9: assert property (@(posedge clk) disable iff (rst)
        page_fail |-> !buf_wr);

    // R6: out-of-range symbols leave the engine ready
    assert_range_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !in_range) |=> req_ready);

    // R4: every access stays inside the page-plus-spare space
    assert_addr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (buf_rd || buf_wr) |-> (int'(buf_addr) < BUF_BYTES));

endmodule

// File: tb/test_ecc_symbol_fixer.sv
module test_ecc_symbol_fixer;
    localparam int PAGE  = 2048;
    localparam int SPARE = 64;
    localparam int BYTES = PAGE + SPARE;
    localparam int LASTS = 1407;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        new_page = 1'b0, page_fail = 1'b0, req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_pos = '0;
    logic [11:0] req_pat = '0;
    logic        buf_rd, buf_wr;
    logic [11:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic [2:0]  corr_count;
    logic        uncorrectable;

    logic [7:0] mem  [BYTES];
    logic [7:0] refm [BYTES];
    int errors = 0, checks = 0, cycles = 0, exp_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecc_symbol_fixer i_ecc_symbol_fixer (
        .clk(clk), .rst(rst), .new_page(new_page), .page_fail(page_fail),
        .req_valid(req_valid), .req_ready(req_ready), .req_pos(req_pos),
        .req_pat(req_pat), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .corr_count(corr_count), .uncorrectable(uncorrectable));

    always_ff @(posedge clk) begin
        if (buf_rd) buf_rdata <= mem[buf_addr];
        if (buf_wr) mem[buf_addr] <= buf_wdata;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < BYTES; i++)
            if (mem[i] !== refm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: byte %0d actual=%02h expected=%02h (%0d bad)",
                     req, first, mem[first], refm[first], bad);
        end
    endtask

    // Reference patch from R1..R4
    function automatic void ref_apply(input int p, input logic [11:0] v);
        int b = (3 * p) / 2;
        if (p == 0) refm[0] ^= v[7:0];
        else if (p % 2 == 1) begin
            refm[b]     ^= v[11:4];
            refm[b + 1] ^= {v[3:0], 4'h0};
        end else begin
            refm[b - 1] ^= {4'h0, v[11:8]};
            refm[b]     ^= v[7:0];
        end
    endfunction

    task automatic send(input int p, input logic [11:0] v, input int fail_at,
                        output int busy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_pos = 11'(p); req_pat = v;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        for (int k = 1; k <= 6; k++) begin
            page_fail = (k == fail_at);
            if (!req_ready) busy++;
            @(negedge clk);
        end
        page_fail = 1'b0;
    endtask

    task automatic fresh_page();
        @(negedge clk); new_page = 1'b1;
        @(negedge clk); new_page = 1'b0;
        exp_cnt = 0;
    endtask

    task automatic good(input int p, input logic [11:0] v, input string req);
        int busy;
        int exp_busy = (p == 0) ? 2 : 4;
        send(p, v, 0, busy);
        ref_apply(p, v);
        exp_cnt++;
        check_mem(req);
        check({"R5 busy ", req}, busy, exp_busy);
        check({"R7 count ", req}, int'(corr_count), exp_cnt);
    endtask

    initial begin
        int busy;
        void'($urandom(32'd1234));
        for (int i = 0; i < BYTES; i++) begin
            mem[i]  = 8'($urandom);
            refm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 ready", int'(req_ready), 1);
        check("R10 count", int'(corr_count), 0);
        check("R10 uncorr", int'(uncorrectable), 0);
        check("R10 strobes", int'(buf_rd | buf_wr), 0);
        @(negedge clk); rst = 1'b0;

        good(5, 12'hABC, "R1 odd");
        good(6, 12'h3E7, "R2 even");
        good(0, 12'hF5A, "R3 zero");
        fresh_page();
        check("R11 clear count", int'(corr_count), 0);
        good(1365, 12'h9C3, "R4 straddle");
        good(1366, 12'h5A5, "R4 spare even");
        good(LASTS, 12'h7E1, "R4 last");
        // R6: out of range
        send(LASTS + 1, 12'hFFF, 0, busy);
        check("R6 busy", busy, 0);
        check_mem("R6 mem");
        check("R6 count", int'(corr_count), exp_cnt);
        good(2, 12'h0F0, "R2 lowest even");
        // R7: fifth request dropped
        send(11, 12'h123, 0, busy);
        check("R7 limit busy", busy, 0);
        check_mem("R7 limit mem");
        check("R7 limit count", int'(corr_count), 4);

        // R9: fail hits second write; first byte stays patched
        fresh_page();
        send(7, 12'hC6D, 4, busy);
        refm[10] ^= 8'hC6;
        check_mem("R9 second write");
        check("R9 count", int'(corr_count), 0);
        check("R9 uncorr", int'(uncorrectable), 1);
        // R8: requests dropped while failed
        send(9, 12'h456, 0, busy);
        check("R8 busy", busy, 0);
        check_mem("R8 mem");
        check("R8 count", int'(corr_count), 0);
        // R9: fail hits first write; nothing changes
        fresh_page();
        check("R11 clear uncorr", int'(uncorrectable), 0);
        send(20, 12'h8B4, 2, busy);
        check_mem("R9 first write");
        check("R9 count first", int'(corr_count), 0);
        fresh_page();

        // Random pages: R1 R2 R3 R4 R7
        for (int pg = 0; pg < 40; pg++) begin
            int n = 1 + int'($urandom % 4);
            for (int j = 0; j < n; j++) begin
                int p = int'($urandom % (LASTS + 1));
                if (j == 0 && pg % 10 == 0) p = 0;
                good(p, 12'($urandom), "R1 R2 random");
            end
            fresh_page();
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule